// File: doc/BRIEF.md
# Audio Transmit Interrupt Status Unit

This block produces the single interrupt line of an audio transmit channel. It takes three status flags from the channel (FIFO empty, FIFO at or below half full, transmitter busy) and a pulse that reports a FIFO underrun. From these it derives three raw interrupt bits: underrun, half-empty and transmit-complete. The raw bits are ANDed with a software enable mask. The line is high whenever any enabled raw bit is set.

The raw bits and the line are not recomputed continuously. They are captured again on every register write and on every drain event from the channel. Between those moments they hold their last value, even if the flags change. Underrun is sticky: once reported, it stays set until software writes the clear register with the underrun-clear bit set. A simple register port gives access to three registers: the enable mask (read/write), the clear register (write-only, reads as zero) and the raw status (read-only).

Top module: `aud_tx_irq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the raw status reads zero, the enable mask reads zero, and irq is low.
- R2: At each evaluation, raw bit 1 (half-empty) takes the value of fifo_half. An evaluation is any cycle with wr_en high or drain_evt high.
- R3: At each evaluation, raw bit 0 (transmit-complete) is set only when fifo_empty is high and tx_busy is low.
- R4: A cycle with underrun_set high sets a sticky underrun flag. Raw bit 2 shows this flag from the next evaluation on. The flag stays set across later evaluations and flag changes.
- R5: A write to the clear address (1) with data bit 0 set clears the underrun flag, and raw bit 2 reads 0 from that write on. A clear write with bit 0 at 0, or a write to any other address, leaves the flag set.
- R6: From the edge that performs an evaluation, irq equals the OR of (raw bits AND enable mask). A mask write takes effect in that same evaluation.
- R7: Without an evaluation, the raw status and irq hold their values, even while fifo_empty, fifo_half or tx_busy change.
- R8: Reading the raw address (2) returns the raw bits in bits [6:0], with bit 0 complete, bit 1 half-empty and bit 2 underrun. All higher bits read as zero, and so does every read of the clear address.
- R9: The enable mask at address 0 stores wr_data[2:0], one bit per raw bit in the same positions. It reads back in bits [2:0] with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe; also triggers an evaluation |
| wr_addr | input | AW | Write address (0 mask, 1 clear, 2 raw) |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data from the registered state |
| fifo_empty | input | 1 | Transmit FIFO holds no samples |
| fifo_half | input | 1 | Transmit FIFO is at or below half full |
| tx_busy | input | 1 | Transmitter still shifting data |
| underrun_set | input | 1 | Pulse reporting a transmit underrun |
| drain_evt | input | 1 | Pulse marking a drain of the FIFO; triggers an evaluation |
| irq | output | 1 | Interrupt request |

## Verification
The flags are driven with half-empty alone, empty with and without busy, and underrun pulses. This separates the three raw bits and shows that the complete bit needs both empty and not busy. Masks that select one source at a time show that the line follows only enabled bits. A mask write made while the matching raw bit is already set shows that the write itself re-evaluates the line. Clear writes with bit 0 at 0, writes to the mask address, and flag changes without any strobe show the difference between a sticky flag and a held sample on one side, and the real clear and re-evaluation paths on the other.

// File: rtl/aud_irq_pkg.sv
// Shared constants for the audio transmit interrupt unit.
// Assumes three sources whose bit positions are fixed, because software decodes them.
package aud_irq_pkg;
    localparam int NSRC         = 3;   // number of raw interrupt sources
    localparam int SRC_DONE     = 0;   // transmit-complete bit
    localparam int SRC_HALF     = 1;   // half-empty bit
    localparam int SRC_UNDR     = 2;   // underrun bit
    localparam int RAW_VIS      = 7;   // visible width of the raw status read
    localparam int CLR_UNDR_BIT = 0;   // bit of the clear register that clears underrun
endpackage

// File: rtl/aud_irq_sticky.sv
// Sticky underrun flag.
// Assumes the set and clear requests are single-cycle and registered upstream.
// If set and clear arrive together, set wins, so that a new event is never lost.
module aud_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic ur_q,
    output logic ur_next
);
    // Next value of the flag: set has priority over clear.
    always_comb begin
        ur_next = ur_q;
        if (clr_req) ur_next = 1'b0;
        if (set_req) ur_next = 1'b1;
    end

    // Flag register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ur_q <= 1'b0;
        else        ur_q <= ur_next;
    end

    // R4: the flag is not dropped without a clear request.
    a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ur_q && !clr_req) |=> ur_q);

    // R5: a clear request without a competing set leaves the flag low.
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req) |=> !ur_q);
endmodule

// File: rtl/aud_irq_regs.sv
// Register port: enable mask (RW), underrun clear (write-only), raw status (RO).
// Assumes single-cycle write strobes. Reads are combinational from registered state.
module aud_irq_regs
    import aud_irq_pkg::*;
#(
    parameter int          AW         = 4,
    parameter int          DW         = 32,
    parameter logic [AW-1:0] ADDR_MASK  = 0,
    parameter logic [AW-1:0] ADDR_CLEAR = 1,
    parameter logic [AW-1:0] ADDR_RAW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    input  logic [NSRC-1:0] raw_q,
    output logic [NSRC-1:0] mask_q,
    output logic [NSRC-1:0] mask_next,
    output logic            clr_req,
    output logic [DW-1:0]   rd_data
);
    localparam int PAD = RAW_VIS - NSRC;

    logic mask_wr;
    logic unused_wdata;

    assign mask_wr      = wr_en && (wr_addr == ADDR_MASK);
    assign clr_req      = wr_en && (wr_addr == ADDR_CLEAR) && wr_data[CLR_UNDR_BIT];
    assign mask_next    = mask_wr ? wr_data[NSRC-1:0] : mask_q;
    assign unused_wdata = ^wr_data[DW-1:NSRC];

    // Enable mask register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_next;
    end

    // Read mux: mask and raw zero-extended, everything else zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_MASK)     rd_data = DW'(mask_q);
        else if (rd_addr == ADDR_RAW) rd_data = DW'({{PAD{1'b0}}, raw_q});
    end

    // R9: the mask changes only through a mask write.
    a_r9_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q));
endmodule

// File: rtl/aud_irq_eval.sv
// Captures the raw interrupt bits and the interrupt line on each evaluation strobe.
// Assumes the strobe is high on every register write and every drain event.
module aud_irq_eval
    import aud_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            eval,
    input  logic            fifo_empty,
    input  logic            fifo_half,
    input  logic            tx_busy,
    input  logic            ur_next,
    input  logic [NSRC-1:0] mask_next,
    input  logic [NSRC-1:0] mask_q,
    output logic [NSRC-1:0] raw_q,
    output logic            irq_q
);
    logic [NSRC-1:0] raw_next;

    // Raw bits as they would be sampled now.
    always_comb begin
        raw_next           = '0;
        raw_next[SRC_DONE] = fifo_empty && !tx_busy;
        raw_next[SRC_HALF] = fifo_half;
        raw_next[SRC_UNDR] = ur_next;
    end

    // Capture the raw bits and the masked line only on evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
            irq_q <= 1'b0;
        end else if (eval) begin
            raw_q <= raw_next;
            irq_q <= |(raw_next & mask_next);
        end
    end

    // R7: without an evaluation, the raw bits and the line hold.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !eval |=> ($stable(raw_q) && $stable(irq_q)));

    // R6: after an evaluation, the line agrees with the registered raw bits and mask.
    a_r6_line: assert property (@(posedge clk) disable iff (!rst_n)
        eval |=> (irq_q == |(raw_q & mask_q)));

    // R3: a busy transmitter never reports completion.
    a_r3_busy_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && tx_busy) |=> !raw_q[SRC_DONE]);

    // R2: the half-empty bit is the sampled flag.
    a_r2_half: assert property (@(posedge clk) disable iff (!rst_n)
        eval |=> (raw_q[SRC_HALF] == $past(fifo_half)));
endmodule

// File: rtl/aud_tx_irq.sv
// Interrupt status unit of an audio transmit channel.
// Derives underrun, half-empty and complete bits and masks them onto one line.
// Assumes the flags come from the channel's clock domain and the strobes are single-cycle pulses.
module aud_tx_irq
    import aud_irq_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          fifo_empty,
    input  logic          fifo_half,
    input  logic          tx_busy,
    input  logic          underrun_set,
    input  logic          drain_evt,
    output logic          irq
);
    logic [NSRC-1:0] raw_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] mask_next;
    logic            clr_req;
    logic            ur_q;
    logic            ur_next;
    logic            eval;

    assign eval = wr_en || drain_evt;

    aud_irq_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .raw_q(raw_q),
        .mask_q(mask_q), .mask_next(mask_next), .clr_req(clr_req),
        .rd_data(rd_data)
    );

    aud_irq_sticky u_sticky (
        .clk(clk), .rst_n(rst_n), .set_req(underrun_set), .clr_req(clr_req),
        .ur_q(ur_q), .ur_next(ur_next)
    );

    aud_irq_eval u_eval (
        .clk(clk), .rst_n(rst_n), .eval(eval), .fifo_empty(fifo_empty),
        .fifo_half(fifo_half), .tx_busy(tx_busy), .ur_next(ur_next),
        .mask_next(mask_next), .mask_q(mask_q), .raw_q(raw_q), .irq_q(irq)
    );

    // R4: once evaluated, the raw underrun bit matches the sticky flag.
    a_r4_raw_tracks_flag: assert property (@(posedge clk) disable iff (!rst_n)
        eval |=> (raw_q[SRC_UNDR] == ur_q));
endmodule

// File: tb/tb_aud_tx_irq.sv
module tb_aud_tx_irq;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_MASK = 0, A_CLR = 1, A_RAW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic fifo_empty = 1'b0, fifo_half = 1'b0, tx_busy = 1'b0;
    logic underrun_set = 1'b0, drain_evt = 1'b0;
    logic irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    aud_tx_irq #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .fifo_empty(fifo_empty), .fifo_half(fifo_half), .tx_busy(tx_busy),
        .underrun_set(underrun_set), .drain_evt(drain_evt), .irq(irq)
    );

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Read a register (combinational) and compare.
    task automatic rd_check(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic drain(input logic ur);
        @(negedge clk);
        drain_evt = 1'b1; underrun_set = ur;
        @(negedge clk);
        drain_evt = 1'b0; underrun_set = 1'b0;
    endtask

    task automatic set_flags(input logic e, input logic h, input logic b);
        @(negedge clk);
        fifo_empty = e; fifo_half = h; tx_busy = b;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_check("R1 raw after reset", A_RAW, 0);
        rd_check("R1 mask after reset", A_MASK, 0);
        check("R1 irq after reset", DW'(irq), 0);
    endtask

    task automatic t_half;
        set_flags(1'b0, 1'b1, 1'b1);
        drain(1'b0);
        rd_check("R2 half bit sampled", A_RAW, 32'h2);
        check("R6 masked off, irq low", DW'(irq), 0);
        wr(A_MASK, 32'h2);
        check("R6 mask write re-evaluates irq", DW'(irq), 1);
        rd_check("R9 mask readback", A_MASK, 32'h2);
    endtask

    task automatic t_complete;
        set_flags(1'b1, 1'b1, 1'b1);
        drain(1'b0);
        rd_check("R3 empty but busy: no complete", A_RAW, 32'h2);
        set_flags(1'b1, 1'b1, 1'b0);
        drain(1'b0);
        rd_check("R3 empty and idle: complete", A_RAW, 32'h3);
        wr(A_MASK, 32'h1);
        check("R6 complete enabled, irq high", DW'(irq), 1);
    endtask

    task automatic t_hold;
        set_flags(1'b0, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        rd_check("R7 raw holds without evaluation", A_RAW, 32'h3);
        check("R7 irq holds without evaluation", DW'(irq), 1);
        drain(1'b0);
        rd_check("R7 drain re-evaluates raw", A_RAW, 32'h0);
        check("R6 irq drops after drain", DW'(irq), 0);
    endtask

    task automatic t_underrun;
        wr(A_MASK, 32'h4);
        drain(1'b1);
        rd_check("R4 underrun set", A_RAW, 32'h4);
        check("R6 underrun enabled, irq high", DW'(irq), 1);
        set_flags(1'b1, 1'b1, 1'b0);
        drain(1'b0);
        rd_check("R4 underrun sticky across drain", A_RAW, 32'h7);
        wr(A_CLR, 32'hFFFF_FFFE);
        rd_check("R5 clear without bit0 ignored", A_RAW, 32'h7);
        wr(A_MASK, 32'h5);
        rd_check("R5 mask write does not clear underrun", A_RAW, 32'h7);
        rd_check("R8 clear address reads zero", A_CLR, 32'h0);
        set_flags(1'b0, 1'b0, 1'b1);
        wr(A_CLR, 32'h1);
        rd_check("R5 clear bit drops underrun", A_RAW, 32'h0);
        check("R6 irq low after clear", DW'(irq), 0);
    endtask

    task automatic t_readback;
        wr(A_MASK, 32'hFFFF_FFFF);
        rd_check("R9 mask keeps only three bits", A_MASK, 32'h7);
        set_flags(1'b1, 1'b1, 1'b0);
        drain(1'b1);
        rd_check("R8 raw all set, upper bits zero", A_RAW, 32'h7);
        check("R6 all enabled, irq high", DW'(irq), 1);
        rd_check("R8 unmapped address reads zero", 4'hF, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_check("R1 reset clears raw", A_RAW, 32'h0);
        check("R1 reset drops irq", DW'(irq), 0);
    endtask

    initial begin
        t_reset();
        t_half();
        t_complete();
        t_hold();
        t_underrun();
        t_readback();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule